// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Per-Word Valid Bits

This block is a read-only cache placed between a processor load port and a slower memory. It has eight lines. Each line keeps one tag and a small number of 32-bit words, and every word has its own valid bit, so a line can be partly filled. A load address is split, from the top down, into a tag, a 3-bit line index, a word-in-line field and a 2-bit byte offset.

When a load hits, the block returns the addressed byte, halfword or word one cycle after it accepts the request. Byte and halfword results are zero-extended. A miss raises `stall` and fetches only the missing word, using a request/acknowledge handshake whose latency can vary. In the cycle the acknowledge arrives, the word, its valid bit and the line tag are written. If the new tag differs from the old one, the other words of that line are invalidated. The stalled load completes on the next cycle. Misaligned loads are answered at once with an error flag and never touch memory.

Top module: `dm_load_cache`

## Requirements
- R1: After reset `stall`, `mem_req` and `rsp_valid` are low and no word is valid, so the first load to any address misses.
- R2: A load is a hit only when the addressed word's valid bit is set and the line tag equals the address tag. A hit gives `rsp_valid` with the data in the cycle after acceptance, without `stall` or `mem_req`.
- R3: An aligned load that misses raises `stall` and `mem_req` in the cycle after acceptance. `mem_addr` carries the word address (request address bits above the byte offset), and both signals hold steady until `mem_ack`.
- R4: `rsp_valid` pulses for exactly one cycle, in the cycle after `mem_ack`. It carries data taken from `mem_data`, and `stall` is low in that cycle.
- R5: Filling one word of a line leaves the other words of that line invalid, so a load to a sibling word with the same tag still misses.
- R6: A fill whose tag differs from the line's stored tag clears the valid bits of every other word in that line.
- R7: With `req_size`=0 the response is the byte at offset `req_addr[1:0]`, taken little-endian (offset k is bits 8k+7:8k), zero-extended.
- R8: With `req_size`=1 the response is the halfword at offset 0 or 2, zero-extended. With `req_size`=2 it is the whole word.
- R9: A halfword load with address bit 0 set, a word load with a nonzero byte offset, or any load with `req_size`=3 gives `rsp_valid` and `rsp_err` in the next cycle with zero data. It causes no stall, no memory request and no change to the cache.
- R10: While `stall` is high, `req_valid` is ignored. Such a request produces no response and no fill.
- R11: Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| stall | output | 1 | Miss outstanding; requests are not accepted |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Zero-extended load data |
| rsp_err | output | 1 | Misaligned or invalid size |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | ADDR_W-2 | Word address of the fetch |
| mem_ack | input | 1 | Fetch done, one-cycle pulse |
| mem_data | input | 32 | Fetched word, valid with `mem_ack` |

## Verification
The bench builds the block with a 10-bit address, which leaves a 4-bit tag over the eight two-word lines. With that width, every byte address can be swept with all four sizes, so every alignment case, every byte lane and every hit or miss outcome per word is reached. A second strided sweep sends each index through repeated tag changes, which exercises eviction and the clearing of sibling words. The bench varies memory latency with the address and holds a competing request during a stall.

// File: rtl/dm_load_cache.sv
module dm_load_cache #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              stall,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic              mem_req,
  output logic [ADDR_W-3:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_data
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - 2 - WOFF_W - IDX_W;
  localparam int IDX_LO = 2 + WOFF_W;
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [WORDS-1:0]  vld_q [LINES];
  logic [31:0]       dat_q [LINES][WORDS];
  logic              filling_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;

  logic [IDX_W-1:0]  r_idx, f_idx;
  logic [WOFF_W-1:0] r_wo, f_wo;
  logic [TAG_W-1:0]  r_tag, f_tag;
  logic              accept, misal, hit;

  assign r_idx = req_addr[TAG_LO-1:IDX_LO];
  assign r_wo  = req_addr[IDX_LO-1:2];
  assign r_tag = req_addr[ADDR_W-1:TAG_LO];
  assign f_idx = addr_q[TAG_LO-1:IDX_LO];
  assign f_wo  = addr_q[IDX_LO-1:2];
  assign f_tag = addr_q[ADDR_W-1:TAG_LO];

  assign accept = req_valid && !filling_q;
  assign misal  = (req_size == 2'd3) ||
                  (req_size == 2'd1 && req_addr[0]) ||
                  (req_size == 2'd2 && req_addr[1:0] != 2'b00);
  assign hit    = vld_q[r_idx][r_wo] && (tag_q[r_idx] == r_tag);

  assign stall    = filling_q;
  assign mem_req  = filling_q;
  assign mem_addr = addr_q[ADDR_W-1:2];

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] off,
                                       input logic [1:0] sz);
    logic [31:0] sh;
    sh = w >> {off, 3'b000};
    case (sz)
      2'd0:    pick = {24'd0, sh[7:0]};
      2'd1:    pick = {16'd0, sh[15:0]};
      default: pick = w;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      addr_q    <= '0;
      size_q    <= '0;
      for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (filling_q) begin
        if (mem_ack) begin
          filling_q <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= pick(mem_data, addr_q[1:0], size_q);
          if (tag_q[f_idx] != f_tag) vld_q[f_idx] <= WORDS'(1) << f_wo;
          else vld_q[f_idx][f_wo] <= 1'b1;
        end
      end else if (accept) begin
        if (misal) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_data  <= '0;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_data  <= pick(dat_q[r_idx][r_wo], req_addr[1:0], req_size);
        end else begin
          filling_q <= 1'b1;
          addr_q    <= req_addr;
          size_q    <= req_size;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (filling_q && mem_ack) begin
      tag_q[f_idx]       <= f_tag;
      dat_q[f_idx][f_wo] <= mem_data;
    end
  end
endmodule

module dm_load_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              stall,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic              rsp_err,
  input logic              mem_req,
  input logic [ADDR_W-3:0] mem_addr,
  input logic              mem_ack
);
  logic [1:0] sz_q;
  logic       bad_align;
  assign bad_align = (req_size == 2'd3) || (req_size == 2'd1 && req_addr[0]) ||
                     (req_size == 2'd2 && req_addr[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) sz_q <= 2'd2;
    else if (req_valid && !stall) sz_q <= req_size;
  end

  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && stall && $stable(mem_addr));
  // R4
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> rsp_valid && !rsp_err && !stall);
  // R9
  misal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !stall && bad_align |=> rsp_valid && rsp_err && rsp_data == 32'd0 && !mem_req);
  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !mem_ack |=> !rsp_valid);
  // R7
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && sz_q == 2'd0 |-> rsp_data[31:8] == 24'd0);
  // R8
  half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && sz_q == 2'd1 |-> rsp_data[31:16] == 16'd0);
endmodule

bind dm_load_cache dm_load_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_err(rsp_err), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/dm_load_cache_bench.sv
module dm_load_cache_bench;
  localparam int CLK_P = 10;
  localparam int AW    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic stall, rsp_valid, rsp_err, mem_req, mem_ack = 1'b0;
  logic [31:0] rsp_data, mem_data = '0;
  logic [AW-3:0] mem_addr;

  int vecs = 0, bad = 0;
  bit mv [8][2];
  logic [3:0] mt [8];

  always #(CLK_P/2) clk = ~clk;

  dm_load_cache #(.ADDR_W(AW)) u_dm_load_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_data(mem_data));

  function automatic logic [31:0] memw(input logic [7:0] wa);
    return {wa ^ 8'hA5, wa + 8'h3C, ~wa, wa};
  endfunction

  function automatic logic [31:0] expv(input logic [31:0] w, input int off, input int sz);
    if (sz == 0) return (w >> (8*off)) & 32'hFF;
    if (sz == 1) return (w >> (8*off)) & 32'hFFFF;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  int lat = 0;
  bit busy = 0;
  initial forever begin
    @(negedge clk);
    if (mem_ack) begin mem_ack = 1'b0; busy = 0; mem_data = 32'hBAD0BAD0; end
    else if (mem_req) begin
      if (!busy) begin busy = 1; lat = int'(mem_addr % 4); end
      if (lat == 0) begin mem_ack = 1'b1; mem_data = memw(mem_addr); end
      else lat--;
    end
  end

  task automatic access(input logic [AW-1:0] a, input int sz, input string tagr,
                        input bit noise = 0, input logic [AW-1:0] na = '0);
    int idx = int'(a[5:3]), wo = int'(a[2]), off = int'(a[1:0]);
    logic [3:0] tg = a[9:6];
    bit mis = (sz == 3) || (sz == 1 && a[0]) || (sz == 2 && off != 0);
    bit hit = mv[idx][wo] && mt[idx] == tg;
    logic [31:0] e = expv(memw(a[9:2]), off, sz);
    int n = 0;
    while (stall) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz);
    @(negedge clk);
    if (noise) begin req_addr = na; req_size = 2'd2; end
    else req_valid = 1'b0;
    if (mis) begin
      chk(rsp_valid && rsp_err && rsp_data == 0 && !stall && !mem_req, "R9", rsp_data, 0);
    end else if (hit) begin
      chk(rsp_valid && !rsp_err && !stall && !mem_req, {tagr, " hit R2"}, {31'd0, rsp_valid}, 1);
      chk(rsp_data == e, {tagr, " data R7 R8"}, rsp_data, e);
    end else begin
      chk(stall && mem_req && !rsp_valid, {tagr, " miss R3"}, {30'd0, stall, mem_req}, 3);
      chk(mem_addr == a[9:2], "R3 mem_addr", 32'(mem_addr), 32'(a[9:2]));
      while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
      req_valid = 1'b0;
      chk(rsp_valid && !rsp_err && !stall, "R4 response", {31'd0, rsp_valid}, 1);
      chk(rsp_data == e, {tagr, " fill data R4 R7 R8"}, rsp_data, e);
      if (mt[idx] != tg) begin mv[idx][0] = 0; mv[idx][1] = 0; end
      mv[idx][wo] = 1; mt[idx] = tg;
      @(negedge clk);
      chk(!rsp_valid, "R4 R10 single response", {31'd0, rsp_valid}, 0);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tg, input int idx, input int wo, input int off);
    return AW'((tg << 6) | (idx << 3) | (wo << 2) | off);
  endfunction

  bit done = 0;
  initial begin
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mv[i][0] = 0; mv[i][1] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !mem_req && !rsp_valid, "R1 reset outputs", {29'd0, stall, mem_req, rsp_valid}, 0);
    access(mk(0, 0, 0, 0), 2, "R1 first");
    // R5: sibling word still invalid
    access(mk(2, 1, 0, 0), 2, "R5");
    access(mk(2, 1, 1, 0), 2, "R5 sibling");
    // R6: tag change clears the other word
    access(mk(1, 2, 0, 0), 2, "R6");
    access(mk(1, 2, 1, 0), 2, "R6");
    access(mk(3, 2, 0, 0), 2, "R6 new tag");
    access(mk(3, 2, 1, 0), 2, "R6 cleared");
    access(mk(1, 2, 1, 0), 2, "R6 old tag");
    // R10: competing request held during stall
    access(mk(5, 4, 0, 0), 2, "R10", 1, mk(6, 5, 1, 0));
    access(mk(6, 5, 1, 0), 2, "R10 ignored");
    // R7 R8 R9: every byte address with every size
    for (int a = 0; a < 1024; a++)
      for (int s = 0; s < 4; s++) access(AW'(a), s, "R7 R8 sweep");
    // R11: strided conflicts across tags
    for (int i = 0; i < 2048; i++) access(AW'((i * 173) % 1024), i % 4, "R11 stride");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule